// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block runs one external memory transfer at a time on a multiplexed 8-bit bus. The core offers a request with a 16-bit address, a write flag, write data and two routing hints. The block then steps through a fixed sequence of clock phases. It drives an active-low address strobe, an active-low data strobe, a read/write line, a shared address/data byte lane and a separate high-address byte. When the transfer ends it returns the captured read byte and a one-cycle completion pulse.

A request goes to the external bus when the core marks it external. An instruction fetch also goes external when the ROM-disable strap input is low, which sends all program fetches off chip. A float input releases every bus output at once, so another master can own the bus, while the internal sequence keeps running.

The defaults are AS_LEN = 2 and DS_LEN = 2, which gives six phases per transfer. Phases 0-1 drive the address with the address strobe low. Phase 2 is the gap after the address strobe rises. Phases 3-4 hold the data strobe low. Phase 5 is recovery.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held and after it releases, `as_n`, `ds_n` and `rw` are 1, `done` is 0, `req_ready` is 1 and no transfer is active.
- R2: An accepted transfer drives `as_n` low for exactly AS_LEN cycles, starting the cycle after acceptance, once per transfer. `a_hi` carries the upper address byte from that cycle on and holds it after the transfer.
- R3: The lane `ad_out` carries the low address byte, unchanged, in every cycle that `as_n` is low. On a read it also holds that byte in the gap cycle after `as_n` rises. In cycles where nothing is driven, `ad_out` is 0.
- R4: `ds_n` is low for exactly DS_LEN cycles, starting one gap cycle after `as_n` rises. `as_n` and `ds_n` are never low together.
- R5: For a write, `rw` is 0 in every cycle of the transfer and 1 at all other times. Write data is on the lane from the gap cycle through the last `ds_n` low cycle, so it is stable when `ds_n` falls.
- R6: For a read, the lane is released from the first `ds_n` low cycle on. `rdata` takes `ad_in` as sampled at the clock edge that ends the last `ds_n` low cycle, and `rdata` is valid while `done` is high.
- R7: While `float_bus` is 1, `ctl_oe` and `ad_oe` are 0, and the strobe sequence continues unchanged. Otherwise `ctl_oe` is 1, and `ad_oe` is 1 exactly in the cycles where R3 or R5 drive the lane.
- R8: A request starts a transfer only if `req_ext` is 1, or if `req_fetch` is 1 and `rom_strap_n` is 0. Any other request is ignored: no strobe moves and `done` stays 0.
- R9: `req_ready` is 1 when idle and in the recovery cycle. A request accepted in the recovery cycle starts the next transfer with no idle cycle in between.
- R10: `done` is 1 for exactly the recovery cycle of each transfer and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ext | input | 1 | Request address lies outside internal memory |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block can accept a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| rom_strap_n | input | 1 | Low = every fetch goes external |
| float_bus | input | 1 | 1 = release all bus outputs |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | Read/write line, low on write |
| ctl_oe | output | 1 | Output enable for strobes, rw and a_hi |
| ad_out | output | 8 | Multiplexed address/data lane out |
| ad_in | input | 8 | Lane input for read data |
| ad_oe | output | 1 | Lane output enable |
| a_hi | output | 8 | High address byte |

## Verification
The bench uses the default AS_LEN = 2 and DS_LEN = 2. With these values, each phase boundary is a single cycle, so a strobe that is off by one cycle shows up as a miscompare. The bench changes `ad_in` every cycle, so only a capture on the edge that ends the last data-strobe cycle gives the expected `rdata`. The stimulus includes back-to-back requests accepted in the recovery cycle, a write with the bus floated, and fetches under both strap levels.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_ADDR = 2'd1,
    LANE_DATA = 2'd2
  } lane_sel_e;

  // Decide what the shared byte lane carries in a given phase.
  function automatic lane_sel_e lane_pick(input int ph, input logic wr,
                                          input int as_len, input int ds_len);
    if (ph < as_len)               return LANE_ADDR;
    else if (ph == as_len)         return wr ? LANE_DATA : LANE_ADDR;
    else if (ph <= as_len + ds_len) return wr ? LANE_DATA : LANE_IDLE;
    else                           return LANE_IDLE;
  endfunction

  function automatic logic in_span(input int ph, input int lo, input int hi);
    return (ph >= lo) && (ph <= hi);
  endfunction

endpackage

// File: rtl/ebs_phase_ctr.sv
module ebs_phase_ctr #(
  parameter int N_PH = 6,
  parameter int PH_W = $clog2(N_PH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            active,
  output logic [PH_W-1:0] ph,
  output logic            last
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(N_PH - 1);

  assign last = active && (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
    end else if (start) begin
      active <= 1'b1;
      ph     <= '0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      ph     <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen
  import ebs_pkg::*;
#(
  parameter int AS_LEN = 2,
  parameter int DS_LEN = 2,
  parameter int PH_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [PH_W-1:0] ph,
  input  logic            last,
  input  logic            wr_q,
  output logic            as_n,
  output logic            ds_n,
  output logic            rw,
  output logic            done
);
  localparam int DS_FIRST = AS_LEN + 1;
  localparam int DS_END   = AS_LEN + DS_LEN;

  logic as_on, ds_on;
  assign as_on = active && in_span(int'(ph), 0, AS_LEN - 1);
  assign ds_on = active && in_span(int'(ph), DS_FIRST, DS_END);

  assign as_n = ~as_on;
  assign ds_n = ~ds_on;
  assign rw   = ~(active && wr_q);
  assign done = last;

  a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(!as_n && !ds_n));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_rw_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> rw);
endmodule

// File: rtl/ebs_lane_mux.sv
module ebs_lane_mux
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int AS_LEN = 2,
  parameter int DS_LEN = 2,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              active,
  input  logic [PH_W-1:0]   ph,
  input  logic [DATA_W-1:0] ad_in,
  input  logic              float_bus,
  output logic              wr_q,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int DS_END = AS_LEN + DS_LEN;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  lane_sel_e         sel;
  logic              cap_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  assign sel     = active ? lane_pick(int'(ph), wr_q, AS_LEN, DS_LEN) : LANE_IDLE;
  assign cap_now = active && !wr_q && (int'(ph) == DS_END);

  always_comb begin
    unique case (sel)
      LANE_ADDR: ad_out = addr_q[DATA_W-1:0];
      LANE_DATA: ad_out = wdata_q;
      default:   ad_out = '0;
    endcase
  end

  assign ad_oe = !float_bus && (sel != LANE_IDLE);
  assign a_hi  = addr_q[ADDR_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (cap_now) rdata <= ad_in;
  end

  a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |-> !ad_oe);

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed DATA_W");
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int AS_LEN = 2,
  parameter int DS_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ext,
  input  logic              req_fetch,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              rom_strap_n,
  input  logic              float_bus,
  output logic              as_n,
  output logic              ds_n,
  output logic              rw,
  output logic              ctl_oe,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi
);
  localparam int N_PH = AS_LEN + DS_LEN + 2;
  localparam int PH_W = $clog2(N_PH);

  logic            active, last, start, go_ext, wr_q;
  logic [PH_W-1:0] ph;

  assign go_ext    = req_ext || (req_fetch && !rom_strap_n);
  assign req_ready = !active || last;
  assign start     = req_valid && req_ready && go_ext;
  assign ctl_oe    = !float_bus;

  ebs_phase_ctr #(.N_PH(N_PH), .PH_W(PH_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start),
    .active(active), .ph(ph), .last(last));

  ebs_strobe_gen #(.AS_LEN(AS_LEN), .DS_LEN(DS_LEN), .PH_W(PH_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .active(active), .ph(ph), .last(last),
    .wr_q(wr_q), .as_n(as_n), .ds_n(ds_n), .rw(rw), .done(done));

  ebs_lane_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AS_LEN(AS_LEN),
                 .DS_LEN(DS_LEN), .PH_W(PH_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .active(active), .ph(ph),
    .ad_in(ad_in), .float_bus(float_bus), .wr_q(wr_q), .ad_out(ad_out),
    .ad_oe(ad_oe), .a_hi(a_hi), .rdata(rdata));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && $past(!as_n)) |-> ($stable(ad_out) && $stable(a_hi)));

  a_r5_wdata_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ds_n) && !rw) |-> $stable(ad_out));

  a_r7_float_all: assert property (@(posedge clk) disable iff (!rst_n)
    float_bus |-> (!ctl_oe && !ad_oe));

  a_r8_ignored_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !go_ext && !active) |=> (as_n && !done));
endmodule

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  localparam int AS_LEN = 2, DS_LEN = 2, AW = 16, DW = 8;
  localparam int NPH = AS_LEN + DS_LEN + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b1;
  logic req_valid = 0, req_ext = 0, req_fetch = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ad_in = '0;
  logic rom_strap_n = 1'b1, float_bus = 1'b0;
  logic req_ready, done, as_n, ds_n, rw, ctl_oe, ad_oe;
  logic [DW-1:0] rdata, ad_out;
  logic [AW-DW-1:0] a_hi;

  ext_bus_seq #(.ADDR_W(AW), .DATA_W(DW), .AS_LEN(AS_LEN), .DS_LEN(DS_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ext(req_ext),
    .req_fetch(req_fetch), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
    .rom_strap_n(rom_strap_n), .float_bus(float_bus), .as_n(as_n), .ds_n(ds_n),
    .rw(rw), .ctl_oe(ctl_oe), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
    .a_hi(a_hi));

  int vecs = 0, errs = 0;
  bit fin = 0;

  task automatic chk(input string tag, input string nm,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // Behavioural reference: a transfer is a phase number walking 0..NPH-1.
  int m_act = 0, m_ph = 0;
  logic m_wr = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;
  bit m_rdy, m_go;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_ph = 0; m_wr = 0; m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      m_rdy = (m_act == 0) || (m_ph == NPH - 1);
      if (m_act != 0 && !m_wr && m_ph == AS_LEN + DS_LEN) m_rd = ad_in;
      m_go = req_valid && m_rdy && (req_ext || (req_fetch && !rom_strap_n));
      if (m_go) begin
        m_act = 1; m_ph = 0; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
      end else if (m_act != 0) begin
        if (m_ph == NPH - 1) m_act = 0;
        else m_ph++;
      end
    end
  end

  always @(negedge clk) begin
    if (!fin) begin
      bit on, a_drv, d_drv;
      logic [DW-1:0] e_lane;
      on    = (m_act != 0);
      a_drv = on && (m_ph < AS_LEN || (m_ph == AS_LEN && !m_wr));
      d_drv = on && m_wr && m_ph >= AS_LEN && m_ph <= AS_LEN + DS_LEN;
      e_lane = a_drv ? m_addr[DW-1:0] : (d_drv ? m_wd : '0);
      chk("R2", "as_n", as_n, !(on && m_ph < AS_LEN));
      chk("R4", "ds_n", ds_n, !(on && m_ph > AS_LEN && m_ph <= AS_LEN + DS_LEN));
      chk("R5", "rw", rw, !(on && m_wr));
      chk("R10", "done", done, on && m_ph == NPH - 1);
      chk("R9", "req_ready", req_ready, !on || m_ph == NPH - 1);
      chk("R3", "ad_out", ad_out, e_lane);
      chk("R7", "ad_oe", ad_oe, !float_bus && (a_drv || d_drv));
      chk("R7", "ctl_oe", ctl_oe, !float_bus);
      chk("R2", "a_hi", a_hi, m_addr[AW-1:DW]);
      chk("R6", "rdata", rdata, m_rd);
    end
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      ad_in = ad_in + 8'h35;
    end
  end

  task automatic issue(input logic ext, input logic fet, input logic wr,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1; req_ext = ext; req_fetch = fet; req_write = wr;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #2;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #1 rst_n = 0;
    @(negedge clk);
    chk("R1", "as_n", as_n, 1); chk("R1", "ds_n", ds_n, 1);
    chk("R1", "rw", rw, 1);     chk("R1", "done", done, 0);
    chk("R1", "req_ready", req_ready, 1);
    @(posedge clk); #2 rst_n = 1;
    idle(2);
    issue(1, 0, 0, 16'h1234, 8'h00);         // R6 read
    idle(8);
    issue(1, 0, 1, 16'hA5C3, 8'h5A);         // R5 write
    idle(8);
    issue(0, 1, 0, 16'h0040, 8'h00);         // R8 fetch, strap high: ignored
    @(negedge clk);
    chk("R8", "as_n", as_n, 1); chk("R8", "done", done, 0);
    idle(4);
    rom_strap_n = 0;
    issue(0, 1, 0, 16'h0F81, 8'h00);         // R8 fetch forced external
    idle(8);
    issue(0, 0, 1, 16'h0011, 8'h77);         // R8 internal data access: ignored
    idle(4);
    issue(1, 0, 0, 16'h2001, 8'h00);         // R9 back-to-back chain
    issue(1, 0, 1, 16'h3002, 8'hC6);
    issue(1, 1, 0, 16'hFFFF, 8'h00);
    issue(1, 0, 1, 16'h0000, 8'hFF);
    idle(8);
    float_bus = 1;                           // R7 floated write
    issue(1, 0, 1, 16'h4E4E, 8'h3B);
    idle(3);
    float_bus = 0;
    idle(6);
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      errs++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule